// File: doc/BRIEF.md
# Configurable Inverter Cell with Falling-Edge Interrupt

This block is one programmable logic cell whose output is the logical NOT of a signal picked from a bank of sixteen sources. A small write/read register interface on the system clock sets up the cell. It holds a free-form function byte, the source index and the sampling mode, the output routing, and the run and interrupt enables. While the cell runs, the inverted value appears on exactly one of four global output lines, or on none when output routing is off. While the cell is stopped, every line is held low.

The selected source can be sampled in three ways: captured on the system clock, captured on a phase-aligned clock at twice that rate, or passed straight through without a register. Each falling edge of the selected source, which is a rising edge of the inverted output, can raise a one-cycle interrupt pulse. A mask bit gates that pulse. In the unregistered mode the edge is found after a two-flop synchronizer into the system clock domain. The cell is used as a glue inverter between neighbouring logic, or as a falling-edge interrupt source on an external signal.

Top module: `inv_cell`

## Requirements
- R1: While the run bit is set, the value presented for the selected source is inverted and driven on the routed output line.
- R2: While the run bit (control register bit 0) is clear, all output lines are low whatever the source inputs do.
- R3: Bits [3:0] of the input register (address 1) pick the source: value n selects src_in[n].
- R4: Output register (address 2) bit 2 enables output routing, and bits [1:0] pick the line. Only the picked line may be high. All lines are low when bit 2 is clear.
- R5: Input register bits [5:4] choose sampling. 00 registers the source on clk, so a change shows after the next clk rising edge. 01 registers it on clk2x. 10 and 11 pass it through combinationally.
- R6: In modes 00 and 01, a falling edge of the selected source gives an irq pulse exactly one period long in the sampling clock (clk or clk2x). A rising edge gives no pulse.
- R7: In modes 10 and 11, a falling edge reaches irq after a two-flop synchronizer on clk. It gives a pulse of one clk period that does not appear in the same half-cycle as the input change.
- R8: irq fires only when both control bit 0 (run) and control bit 1 (interrupt enable) are set. An edge that happened while the cell was stopped is not reported when the cell is later started.
- R9: After reset, every register reads zero, all output lines are low and irq is low.
- R10: Registers read back at addresses 0 (function, all 8 bits), 1 (bits [5:0]), 2 (bits [2:0]) and 3 (bits [1:0]). Unused bits read zero. The function byte has no effect on outputs or irq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clk2x | input | 1 | Double-rate clock, rising edges aligned with clk |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sampled on clk |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| src_in | input | 16 | Source signals |
| gout | output | 4 | Global output lines |
| irq | output | 1 | Falling-edge interrupt pulse |

## Verification
The hardest case to reach is the exact length and latency of the interrupt pulse in each sampling mode. In the double-rate mode it lasts only half a system cycle. In the unregistered mode it trails the input by two system edges. The stimulus changes sources on falling edges of the fast clock and samples outputs twice per fast period. For each mode it makes a single falling edge from a settled high level and counts how many samples see irq high. The mask and stopped-cell cases come from the same kind of edge, one with the enable bits cleared and one where the edge falls before the run bit is set.

// File: rtl/inv_cell_pkg.sv
`timescale 1ns/100ps
package inv_cell_pkg;
    localparam int DEF_SRCS  = 16;
    localparam int DEF_LINES = 4;
    localparam int DEF_DW    = 8;
    localparam int AW        = 2;

    localparam logic [AW-1:0] A_FUNC = 2'd0;
    localparam logic [AW-1:0] A_INP  = 2'd1;
    localparam logic [AW-1:0] A_OUT  = 2'd2;
    localparam logic [AW-1:0] A_CTL  = 2'd3;

    typedef enum logic [1:0] {
        SMP_SYS  = 2'd0,
        SMP_DBL  = 2'd1,
        SMP_RAW  = 2'd2,
        SMP_RAW2 = 2'd3
    } smp_mode_e;
endpackage

// File: rtl/inv_cell_regs.sv
`timescale 1ns/100ps
module inv_cell_regs
    import inv_cell_pkg::*;
#(
    parameter int DW     = DEF_DW,
    parameter int SEL_W  = 4,
    parameter int LINE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic [SEL_W-1:0]  sel,
    output logic [1:0]        mode,
    output logic              out_en,
    output logic [LINE_W-1:0] line,
    output logic              run,
    output logic              irq_en
);
    typedef struct packed {
        logic [DW-1:0]     func;
        logic [SEL_W-1:0]  sel;
        logic [1:0]        mode;
        logic              out_en;
        logic [LINE_W-1:0] line;
        logic              run;
        logic              irq_en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_addr)
                A_FUNC: cfg_d.func = wr_data;
                A_INP: begin
                    cfg_d.sel  = wr_data[SEL_W-1:0];
                    cfg_d.mode = wr_data[SEL_W+1:SEL_W];
                end
                A_OUT: begin
                    cfg_d.line   = wr_data[LINE_W-1:0];
                    cfg_d.out_en = wr_data[LINE_W];
                end
                default: begin
                    cfg_d.run    = wr_data[0];
                    cfg_d.irq_en = wr_data[1];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_FUNC: rd_data = cfg_q.func;
            A_INP: begin
                rd_data[SEL_W-1:0]     = cfg_q.sel;
                rd_data[SEL_W+1:SEL_W] = cfg_q.mode;
            end
            A_OUT: begin
                rd_data[LINE_W-1:0] = cfg_q.line;
                rd_data[LINE_W]     = cfg_q.out_en;
            end
            default: begin
                rd_data[0] = cfg_q.run;
                rd_data[1] = cfg_q.irq_en;
            end
        endcase
    end

    assign sel    = cfg_q.sel;
    assign mode   = cfg_q.mode;
    assign out_en = cfg_q.out_en;
    assign line   = cfg_q.line;
    assign run    = cfg_q.run;
    assign irq_en = cfg_q.irq_en;
endmodule

// File: rtl/inv_cell_sampler.sv
`timescale 1ns/100ps
module inv_cell_sampler
    import inv_cell_pkg::*;
(
    input  logic      clk,
    input  logic      clk2x,
    input  logic      rst_n,
    input  logic      src_bit,
    input  smp_mode_e mode,
    input  logic      run,
    input  logic      irq_en,
    output logic      level,
    output logic      irq
);
    typedef struct packed {
        logic smp;
        logic smp_prev;
        logic sy1;
        logic sy2;
        logic sy2_prev;
    } sys_t;

    typedef struct packed {
        logic smp;
        logic smp_prev;
    } dbl_t;

    sys_t sys_d, sys_q;
    dbl_t dbl_d, dbl_q;
    logic fall;

    always_comb begin
        sys_d          = sys_q;
        sys_d.smp      = src_bit;
        sys_d.smp_prev = sys_q.smp;
        sys_d.sy1      = src_bit;
        sys_d.sy2      = sys_q.sy1;
        sys_d.sy2_prev = sys_q.sy2;
        dbl_d          = dbl_q;
        dbl_d.smp      = src_bit;
        dbl_d.smp_prev = dbl_q.smp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sys_q <= '0;
        else        sys_q <= sys_d;
    end

    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) dbl_q <= '0;
        else        dbl_q <= dbl_d;
    end

    always_comb begin
        case (mode)
            SMP_SYS: begin
                level = sys_q.smp;
                fall  = sys_q.smp_prev & ~sys_q.smp;
            end
            SMP_DBL: begin
                level = dbl_q.smp;
                fall  = dbl_q.smp_prev & ~dbl_q.smp;
            end
            default: begin
                level = src_bit;
                fall  = sys_q.sy2_prev & ~sys_q.sy2;
            end
        endcase
    end

    assign irq = run & irq_en & fall;

    // R6: single clk period pulse when sampling on the system clock
    assert_sys_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SMP_SYS && irq) |=> (mode != SMP_SYS || !irq));

    // R6: single clk2x period pulse in double-rate mode
    assert_dbl_pulse_R6: assert property (@(posedge clk2x) disable iff (!rst_n)
        (mode == SMP_DBL && irq) |=> (mode != SMP_DBL || !irq));

    // R7: unregistered mode pulse lasts one clk period
    assert_raw_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && irq) |=> (!mode[1] || !irq));
endmodule

// File: rtl/inv_cell_route.sv
`timescale 1ns/100ps
module inv_cell_route #(
    parameter int LINES  = 4,
    parameter int LINE_W = 2
) (
    input  logic              run,
    input  logic              level,
    input  logic              out_en,
    input  logic [LINE_W-1:0] line,
    output logic [LINES-1:0]  gout
);
    logic drive;
    assign drive = run & ~level;

    for (genvar k = 0; k < LINES; k++) begin : g_line
        assign gout[k] = out_en && (line == LINE_W'(k)) && drive;
    end
endmodule

// File: rtl/inv_cell.sv
`timescale 1ns/100ps
module inv_cell
    import inv_cell_pkg::*;
#(
    parameter int SRCS  = DEF_SRCS,
    parameter int LINES = DEF_LINES,
    parameter int DW    = DEF_DW
) (
    input  logic             clk,
    input  logic             clk2x,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    input  logic [SRCS-1:0]  src_in,
    output logic [LINES-1:0] gout,
    output logic             irq
);
    localparam int SEL_W  = $clog2(SRCS);
    localparam int LINE_W = $clog2(LINES);

    logic [SEL_W-1:0]  sel;
    logic [1:0]        mode;
    logic              out_en;
    logic [LINE_W-1:0] line;
    logic              run;
    logic              irq_en;
    logic              src_bit;
    logic              level;

    inv_cell_regs #(.DW(DW), .SEL_W(SEL_W), .LINE_W(LINE_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .sel(sel), .mode(mode), .out_en(out_en), .line(line),
        .run(run), .irq_en(irq_en)
    );

    assign src_bit = src_in[sel];

    inv_cell_sampler u_smp (
        .clk(clk), .clk2x(clk2x), .rst_n(rst_n),
        .src_bit(src_bit), .mode(smp_mode_e'(mode)),
        .run(run), .irq_en(irq_en),
        .level(level), .irq(irq)
    );

    inv_cell_route #(.LINES(LINES), .LINE_W(LINE_W)) u_route (
        .run(run), .level(level), .out_en(out_en), .line(line), .gout(gout)
    );

    // R2: stopped cell keeps every line low
    assert_stopped_low_R2: assert property (@(posedge clk2x) disable iff (!rst_n)
        !run |-> (gout == '0));

    // R4: never more than one line high
    assert_one_line_R4: assert property (@(posedge clk2x) disable iff (!rst_n)
        $onehot0(gout));

    // R4: routing off means all lines low
    assert_route_off_R4: assert property (@(posedge clk2x) disable iff (!rst_n)
        !out_en |-> (gout == '0));

    // R8: interrupt only while running
    assert_irq_needs_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> run);
endmodule

// File: tb/inv_cell_test.sv
`timescale 1ns/100ps
module inv_cell_test;
    logic        clk = 1'b0, clk2x = 1'b0, rst_n = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0, rd_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [15:0] src = 16'hFFFF;
    logic [3:0]  gout;
    logic        irq;

    inv_cell uut (
        .clk(clk), .clk2x(clk2x), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .src_in(src), .gout(gout), .irq(irq)
    );

    int    checks = 0, errors = 0, irq_hi = 0;
    bit    cmp_on = 1'b0, ph = 1'b0, done = 1'b0;
    string cur_req = "R9";

    // behavioural reference state
    bit [7:0] m_fn;
    int       m_sel, m_mode, m_line;
    bit       m_oe, m_run, m_ie;
    bit       s_cur, s_prev, r1, r2, r2p, d_cur, d_prev;

    task automatic model_step(input bit sys);
        bit pick;
        if (!rst_n) begin
            m_fn = 0; m_sel = 0; m_mode = 0; m_line = 0;
            m_oe = 0; m_run = 0; m_ie = 0;
            s_cur = 0; s_prev = 0; r1 = 0; r2 = 0; r2p = 0; d_cur = 0; d_prev = 0;
            return;
        end
        pick = src[m_sel];
        if (sys) begin
            s_prev = s_cur; s_cur = pick;
            r2p = r2; r2 = r1; r1 = pick;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_fn = wr_data;
                    2'd1: begin m_sel = wr_data[3:0]; m_mode = wr_data[5:4]; end
                    2'd2: begin m_line = wr_data[1:0]; m_oe = wr_data[2]; end
                    default: begin m_run = wr_data[0]; m_ie = wr_data[1]; end
                endcase
            end
        end
        d_prev = d_cur; d_cur = pick;
    endtask

    task automatic compare();
        bit lvl, fall, e_irq;
        logic [3:0] e_out;
        if (!cmp_on || done) return;
        if (m_mode == 0)      begin lvl = s_cur; fall = s_prev & !s_cur; end
        else if (m_mode == 1) begin lvl = d_cur; fall = d_prev & !d_cur; end
        else                  begin lvl = src[m_sel]; fall = r2p & !r2; end
        e_out = (m_oe && m_run && !lvl) ? (4'b0001 << m_line) : 4'b0000;
        e_irq = m_run & m_ie & fall;
        checks++;
        if (gout !== e_out || irq !== e_irq) begin
            errors++;
            $display("FAIL %s: gout=%b irq=%b expected gout=%b irq=%b at %0t",
                     cur_req, gout, irq, e_out, e_irq, $time);
        end
        if (irq === 1'b1) irq_hi++;
    endtask

    initial begin
        forever begin
            #1;
            clk2x = 1'b1;
            clk   = (ph == 1'b0);
            model_step(ph == 1'b0);
            #0.5 compare();
            #0.5 clk2x = 1'b0;
            #0.5 compare();
            #0.5 ph = ~ph;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk2x);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk2x);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [1:0] a, input int exp);
        @(negedge clk2x);
        rd_addr = a;
        #0.25;
        check(req, int'(rd_data), exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk2x);
    endtask

    task automatic set_src(input logic [15:0] v);
        @(negedge clk2x);
        src = v;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        #0 rst_n = 1'b0;
        #10;
        @(negedge clk2x);
        rst_n = 1'b1;
        wait_cyc(2);
        cmp_on = 1'b1;

        // R9 reset state
        cur_req = "R9";
        #0.5;
        check("R9 gout", int'(gout), 0);
        check("R9 irq", int'(irq), 0);
        for (int a = 0; a < 4; a++) rd_check("R9 readback", 2'(a), 0);

        // R10 readback and masking
        cur_req = "R10";
        wr(2'd0, 8'hA5); rd_check("R10 func", 2'd0, 'hA5);
        wr(2'd1, 8'hFF); rd_check("R10 input", 2'd1, 'h3F);
        wr(2'd2, 8'hFF); rd_check("R10 output", 2'd2, 'h07);
        wr(2'd3, 8'hFF); rd_check("R10 control", 2'd3, 'h03);
        wr(2'd3, 8'h00);
        wr(2'd2, 8'h00);

        // R1 R3 source selection in pass-through mode, line 2
        cur_req = "R3";
        wr(2'd2, 8'h06);
        wr(2'd3, 8'h01);
        for (int s = 0; s < 16; s++) begin
            wr(2'd1, 8'(8'h20 | s));
            set_src(16'(1 << s));
            #0.5 check("R3 selected high", int'(gout), 0);
            set_src(~16'(1 << s));
            #0.5 check("R1 selected low", int'(gout), 4);
        end
        cur_req = "R10";
        wr(2'd0, 8'hFF);
        #0.5 check("R10 func no effect", int'(gout), 4);

        // R4 routing
        cur_req = "R4";
        set_src(16'h0000);
        for (int l = 0; l < 4; l++) begin
            wr(2'd2, 8'(8'h04 | l));
            #0.5 check("R4 line", int'(gout), 1 << l);
        end
        wr(2'd2, 8'h03);
        #0.5 check("R4 routing off", int'(gout), 0);

        // R2 stopped cell, R8 no irq while stopped
        cur_req = "R2";
        wr(2'd2, 8'h05);
        wr(2'd3, 8'h02);
        irq_hi = 0;
        for (int k = 0; k < 12; k++) begin
            set_src(16'(k * 16'h1357));
            #0.5 check("R2 stopped low", int'(gout), 0);
        end
        check("R8 no irq while stopped", irq_hi, 0);

        // R8 edge before start is not reported
        cur_req = "R8";
        wr(2'd1, 8'h03);
        set_src(16'hFFFF); wait_cyc(3);
        set_src(16'hFFF7); wait_cyc(3);
        irq_hi = 0;
        wr(2'd3, 8'h03);
        wait_cyc(4);
        check("R8 no spurious on start", irq_hi, 0);

        // R5 R6 system-clock sampling
        cur_req = "R6";
        set_src(16'hFFFF); wait_cyc(3);
        irq_hi = 0;
        set_src(16'hFFF7);
        #0.5 check("R5 sys registered", int'(gout), 0);
        wait_cyc(3);
        check("R5 sys output", int'(gout), 2);
        check("R6 sys pulse length", irq_hi, 4);
        set_src(16'hFFFF); wait_cyc(3);
        check("R6 no irq on rise", irq_hi, 4);

        // R5 R6 double-rate sampling
        wr(2'd1, 8'h13);
        wait_cyc(3);
        irq_hi = 0;
        set_src(16'hFFF7);
        #0.5 check("R5 dbl registered", int'(gout), 0);
        wait_cyc(3);
        check("R5 dbl output", int'(gout), 2);
        check("R6 dbl pulse length", irq_hi, 2);
        for (int k = 0; k < 20; k++) set_src((k % 3 == 0) ? 16'hFFFF : 16'h0000);

        // R5 R7 pass-through mode
        cur_req = "R7";
        wr(2'd1, 8'h23);
        set_src(16'hFFFF); wait_cyc(4);
        irq_hi = 0;
        set_src(16'hFFF7);
        #0.5 check("R5 raw immediate", int'(gout), 2);
        check("R7 not same cycle", int'(irq), 0);
        wait_cyc(4);
        check("R7 raw pulse length", irq_hi, 4);
        wr(2'd1, 8'h33);
        set_src(16'hFFFF); wait_cyc(4);
        irq_hi = 0;
        set_src(16'h0000); wait_cyc(4);
        check("R7 mode 11 pulse", irq_hi, 4);

        // R8 mask clear blocks irq
        cur_req = "R8";
        wr(2'd3, 8'h01);
        set_src(16'hFFFF); wait_cyc(4);
        irq_hi = 0;
        set_src(16'h0000); wait_cyc(4);
        check("R8 masked raw", irq_hi, 0);
        wr(2'd1, 8'h03);
        set_src(16'hFFFF); wait_cyc(4);
        set_src(16'h0000); wait_cyc(4);
        check("R8 masked sys", irq_hi, 0);
        check("R1 masked output", int'(gout), 2);

        wait_cyc(2);
        done = 1'b1;
        summary();
    end
endmodule